// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the digital state machine of a small microcontroller's power controller. It tracks six operating states: main run, low-power run, sleep, low-power sleep, stop 0 and stop 1. The core asks for a low-power state with a sleep request. A deep select bit chooses between sleep and stop. A regulator control bit chooses the main regulator or the low-power one. A wait-type bit chooses interrupt-wait or event-wait. The block gates the core and peripheral clocks and reports whether the main regulator is on. It also reports a combined low-power/settling flag and a 3-bit mode code.

The analog regulator is replaced by a settle counter. It runs for `SETTLE_CYCLES` clock cycles each time the main regulator is turned back on. A clock-slow input stands in for a measurement of the system clock frequency. Wake-up comes from pending interrupts with their enables, or from a wake event. A sleep-on-exit option lets an interrupt-return strobe send the block back into the sleep or stop kind that was chosen last.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the mode code is 0 (run). Core and peripheral clocks are enabled, the main regulator is on, and `regLpFlag` and `regSettling` are low. `fullSpeedOk` is high.
- R2: The mode codes are 0 run, 1 low-power run, 2 sleep, 3 low-power sleep, 4 stop 0 and 5 stop 1. The core clock is enabled only in codes 0 and 1. The peripheral clock is enabled only in codes 0 to 3. The main regulator is off in codes 1, 3 and 5.
- R3: In run, with no sleep request and no settling, `lpRegCtl`=1 moves the block to low-power run only while `clkSlow`=1. With `clkSlow`=0 it stays in run.
- R4: In low-power run, `lpRegCtl`=0 moves the block to run on the next edge and starts settling. `regSettling` and `regLpFlag` then stay high for exactly `SETTLE_CYCLES` cycles. `fullSpeedOk` rises only after that.
- R5: A sleep request with `deepSel`=0 from run or low-power run enters sleep when `lpRegCtl`=0 and low-power sleep when `lpRegCtl`=1.
- R6: A sleep request with `deepSel`=1 enters stop 0 when `lpRegCtl`=0 and stop 1 when `lpRegCtl`=1.
- R7: Wake destinations are as follows. Sleep goes to run and low-power sleep goes to low-power run. Either stop state goes to run if `lpRegCtl`=0 at the wake and to low-power run if it is 1. A wake from stop 1 into run starts settling.
- R8: If `waitEvt`=0 at entry (interrupt-wait), only an `irqPend` bit whose `irqEn` bit is also set wakes the block. `wakeEvt` and disabled pending interrupts are ignored.
- R9: If `waitEvt`=1 at entry (event-wait), the first cycle in the low-power state never wakes. After that, `wakeEvt` wakes the block. Any `irqPend` bit, even a disabled one, also wakes it when `sevOnPend`=1. With `sevOnPend`=0, pending interrupts are ignored.
- R10: In run or low-power run with no sleep request and no settling, `sleepOnExit`=1 together with `irqReturn`=1 re-enters a low-power state. The sleep/stop kind and the wait type come from the last fresh request, and the regulator choice from the current `lpRegCtl`. Before any fresh request, or with `sleepOnExit`=0, the strobe is ignored.
- R11: While settling, sleep requests, interrupt-return strobes and the regulator bit are ignored, and the block stays in run. A sleep request takes priority over re-entry, and re-entry takes priority over a regulator change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Core requests a low-power state (one-cycle strobe) |
| deepSel | input | 1 | 1 selects stop, 0 selects sleep |
| waitEvt | input | 1 | 1 selects event-wait entry, 0 interrupt-wait |
| lpRegCtl | input | 1 | Regulator control bit, 1 selects the low-power regulator |
| clkSlow | input | 1 | System clock is below the low-frequency limit |
| sevOnPend | input | 1 | Pending interrupts count as wake events in event-wait |
| sleepOnExit | input | 1 | Re-enter the last low-power state on interrupt return |
| irqReturn | input | 1 | Interrupt-return strobe |
| irqPend | input | N_IRQ | Pending interrupt lines |
| irqEn | input | N_IRQ | Interrupt enables |
| wakeEvt | input | 1 | Wake event |
| mode | output | 3 | Current mode code |
| coreClkEn | output | 1 | Core clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| mainRegEn | output | 1 | Main regulator on |
| regLpFlag | output | 1 | Regulator in low-power mode or main regulator still settling |
| regSettling | output | 1 | Main regulator settle window active |
| fullSpeedOk | output | 1 | Run mode with a settled main regulator |

## Verification
Some rules are checked on every cycle. Run is never left for low-power run while the clock is fast. Sleep and low-power sleep wake only to their own run state. The settle counter stays in range and counts down by one each cycle, and the block stays in run while it is nonzero. Interrupt-wait never wakes without an enabled pending interrupt, and event-wait never wakes in its first cycle. Other behaviour can only be shown by the bench scenarios. These are the exact destination of each entry and wake, the length of the settle window as seen at the ports, the priority between request, re-entry and regulator change, and the rule that sleep-on-exit reuses the last selection.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    MODE_RUN     = 3'd0,
    MODE_LPRUN   = 3'd1,
    MODE_SLEEP   = 3'd2,
    MODE_LPSLEEP = 3'd3,
    MODE_STOP0   = 3'd4,
    MODE_STOP1   = 3'd5
  } pmode_e;

  // Strobes from the sequencing control to the datapath
  typedef struct packed {
    logic startSettle;  // main regulator turned back on
    logic armEvt;       // set the internal event latch on entry
    logic consumeEvt;   // first wait consumes the latch
    logic captureSel;   // store selection of a fresh request
  } seq_strobe_t;

  function automatic logic isLowPower(pmode_e m);
    return (m == MODE_SLEEP) || (m == MODE_LPSLEEP) ||
           (m == MODE_STOP0) || (m == MODE_STOP1);
  endfunction

endpackage

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  seq_strobe_t strobe,
  input  pmode_e      curMode,
  input  logic        waitEvt,
  input  logic        deepSel,
  output logic        settling,
  output logic        evtLatch,
  output logic        waitIsEvt,
  output logic        prevDeep,
  output logic        hasPrev,
  output logic        coreClkEn,
  output logic        periphClkEn,
  output logic        mainRegEn,
  output logic        regLpFlag,
  output logic        fullSpeedOk
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] settleCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settleCnt <= '0;
    end else if (strobe.startSettle) begin
      settleCnt <= CNT_LOAD;
    end else if (settleCnt != '0) begin
      settleCnt <= settleCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evtLatch  <= 1'b0;
      waitIsEvt <= 1'b0;
      prevDeep  <= 1'b0;
      hasPrev   <= 1'b0;
    end else begin
      if (strobe.armEvt) evtLatch <= 1'b1;
      else if (strobe.consumeEvt) evtLatch <= 1'b0;
      if (strobe.captureSel) begin
        waitIsEvt <= waitEvt;
        prevDeep  <= deepSel;
        hasPrev   <= 1'b1;
      end
    end
  end

  assign settling    = (settleCnt != '0);
  assign coreClkEn   = (curMode == MODE_RUN) || (curMode == MODE_LPRUN);
  assign periphClkEn = coreClkEn || (curMode == MODE_SLEEP) || (curMode == MODE_LPSLEEP);
  assign mainRegEn   = !((curMode == MODE_LPRUN) || (curMode == MODE_LPSLEEP) ||
                         (curMode == MODE_STOP1));
  assign regLpFlag   = !mainRegEn || settling;
  assign fullSpeedOk = (curMode == MODE_RUN) && !settling;

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    settleCnt <= CNT_LOAD);
  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (settleCnt != '0 && !strobe.startSettle) |=> settleCnt == $past(settleCnt) - CNT_W'(1));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleepReq,
  input  logic             deepSel,
  input  logic             waitEvt,
  input  logic             lpRegCtl,
  input  logic             clkSlow,
  input  logic             sevOnPend,
  input  logic             sleepOnExit,
  input  logic             irqReturn,
  input  logic [N_IRQ-1:0] irqPend,
  input  logic [N_IRQ-1:0] irqEn,
  input  logic             wakeEvt,
  input  logic             settling,
  input  logic             evtLatch,
  input  logic             waitIsEvt,
  input  logic             prevDeep,
  input  logic             hasPrev,
  output pmode_e           state,
  output seq_strobe_t      strobe
);
  pmode_e nextState;
  logic   freshGo, reGo, goDeep, wake, inRun;
  pmode_e sleepTgt;

  assign inRun   = (state == MODE_RUN) || (state == MODE_LPRUN);
  assign freshGo = sleepReq && !settling;
  assign reGo    = !sleepReq && sleepOnExit && irqReturn && hasPrev && !settling;
  assign goDeep  = freshGo ? deepSel : prevDeep;
  assign sleepTgt = goDeep ? (lpRegCtl ? MODE_STOP1 : MODE_STOP0)
                           : (lpRegCtl ? MODE_LPSLEEP : MODE_SLEEP);
  assign wake = !evtLatch && (waitIsEvt ? (wakeEvt || (sevOnPend && (|irqPend)))
                                        : (|(irqPend & irqEn)));

  always_comb begin
    nextState = state;
    strobe    = '0;
    strobe.consumeEvt = isLowPower(state) && evtLatch;
    case (state)
      MODE_RUN, MODE_LPRUN: begin
        if (freshGo || reGo) begin
          nextState         = sleepTgt;
          strobe.captureSel = freshGo;
          strobe.armEvt     = freshGo ? waitEvt : waitIsEvt;
        end else if (state == MODE_RUN && lpRegCtl && clkSlow && !settling) begin
          nextState = MODE_LPRUN;
        end else if (state == MODE_LPRUN && !lpRegCtl) begin
          nextState          = MODE_RUN;
          strobe.startSettle = 1'b1;
        end
      end
      MODE_SLEEP:   if (wake) nextState = MODE_RUN;
      MODE_LPSLEEP: if (wake) nextState = MODE_LPRUN;
      MODE_STOP0:   if (wake) nextState = lpRegCtl ? MODE_LPRUN : MODE_RUN;
      MODE_STOP1: begin
        if (wake) begin
          nextState          = lpRegCtl ? MODE_LPRUN : MODE_RUN;
          strobe.startSettle = !lpRegCtl;
        end
      end
      default: nextState = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= MODE_RUN;
    else        state <= nextState;
  end

  a_r3_lprun_needs_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MODE_RUN && !clkSlow) |=> state != MODE_LPRUN);
  a_r7_sleep_wakes_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MODE_SLEEP) |=> (state == MODE_SLEEP || state == MODE_RUN));
  a_r7_lpsleep_wakes_lprun: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MODE_LPSLEEP) |=> (state == MODE_LPSLEEP || state == MODE_LPRUN));
  a_r11_settle_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    settling |-> (state == MODE_RUN));
  a_r11_settle_holds_run: assert property (@(posedge clk) disable iff (!rst_n)
    settling |=> (state == MODE_RUN));
  a_r8_irq_wait_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (isLowPower(state) && !waitIsEvt && ((irqPend & irqEn) == '0)) |=> $stable(state));
  a_r9_first_wait_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (isLowPower(state) && evtLatch) |=> $stable(state));
  a_r2_lowpower_not_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (inRun && !sleepReq && !irqReturn) |=> !isLowPower(state));

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int N_IRQ         = 8,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleepReq,
  input  logic             deepSel,
  input  logic             waitEvt,
  input  logic             lpRegCtl,
  input  logic             clkSlow,
  input  logic             sevOnPend,
  input  logic             sleepOnExit,
  input  logic             irqReturn,
  input  logic [N_IRQ-1:0] irqPend,
  input  logic [N_IRQ-1:0] irqEn,
  input  logic             wakeEvt,
  output logic [2:0]       mode,
  output logic             coreClkEn,
  output logic             periphClkEn,
  output logic             mainRegEn,
  output logic             regLpFlag,
  output logic             regSettling,
  output logic             fullSpeedOk
);
  pmode_e      curMode;
  seq_strobe_t strobe;
  logic        settling, evtLatch, waitIsEvt, prevDeep, hasPrev;

  pwr_seq_ctrl #(.N_IRQ(N_IRQ)) ctrl (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .deepSel(deepSel),
    .waitEvt(waitEvt), .lpRegCtl(lpRegCtl), .clkSlow(clkSlow),
    .sevOnPend(sevOnPend), .sleepOnExit(sleepOnExit), .irqReturn(irqReturn),
    .irqPend(irqPend), .irqEn(irqEn), .wakeEvt(wakeEvt),
    .settling(settling), .evtLatch(evtLatch), .waitIsEvt(waitIsEvt),
    .prevDeep(prevDeep), .hasPrev(hasPrev), .state(curMode), .strobe(strobe)
  );

  pwr_seq_dp #(.SETTLE_CYCLES(SETTLE_CYCLES)) dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .curMode(curMode),
    .waitEvt(waitEvt), .deepSel(deepSel), .settling(settling),
    .evtLatch(evtLatch), .waitIsEvt(waitIsEvt), .prevDeep(prevDeep),
    .hasPrev(hasPrev), .coreClkEn(coreClkEn), .periphClkEn(periphClkEn),
    .mainRegEn(mainRegEn), .regLpFlag(regLpFlag), .fullSpeedOk(fullSpeedOk)
  );

  assign mode        = curMode;
  assign regSettling = settling;

endmodule

// File: tb/pwr_mode_seq_test.sv
`timescale 1ns/1ps
module pwr_mode_seq_test;
  localparam int NI = 4;
  localparam int SC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleepReq = 0, deepSel = 0, waitEvt = 0, lpRegCtl = 0, clkSlow = 0;
  logic sevOnPend = 0, sleepOnExit = 0, irqReturn = 0, wakeEvt = 0;
  logic [NI-1:0] irqPend = '0, irqEn = '0;
  logic [2:0] mode;
  logic coreClkEn, periphClkEn, mainRegEn, regLpFlag, regSettling, fullSpeedOk;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  pwr_mode_seq #(.N_IRQ(NI), .SETTLE_CYCLES(SC)) uut (
    .clk(clk), .rst_n(rst_n), .sleepReq(sleepReq), .deepSel(deepSel),
    .waitEvt(waitEvt), .lpRegCtl(lpRegCtl), .clkSlow(clkSlow),
    .sevOnPend(sevOnPend), .sleepOnExit(sleepOnExit), .irqReturn(irqReturn),
    .irqPend(irqPend), .irqEn(irqEn), .wakeEvt(wakeEvt), .mode(mode),
    .coreClkEn(coreClkEn), .periphClkEn(periphClkEn), .mainRegEn(mainRegEn),
    .regLpFlag(regLpFlag), .regSettling(regSettling), .fullSpeedOk(fullSpeedOk)
  );

  // fields: req deep lp evt sop soe ret slow wev pend en expMode
  typedef struct packed {
    logic req, deep, lp, evt, sop, soe, ret, slow, wev;
    logic [3:0] pend, en;
    logic [2:0] expMode;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{0,0,0,0,0,0,0,0,0, 4'b0000,4'b0000, 3'd0}, // idle run
    '{0,0,1,0,0,0,0,0,0, 4'b0000,4'b0000, 3'd0}, // R3 clock fast: stay
    '{0,0,1,0,0,0,0,1,0, 4'b0000,4'b0000, 3'd1}, // R3 enter low-power run
    '{1,0,1,0,0,0,0,1,0, 4'b0000,4'b0000, 3'd3}, // R5 low-power sleep
    '{0,0,1,0,0,0,0,0,1, 4'b0000,4'b0000, 3'd3}, // R8 event ignored
    '{0,0,1,0,0,0,0,0,0, 4'b0001,4'b0010, 3'd3}, // R8 disabled irq ignored
    '{0,0,1,0,0,0,0,0,0, 4'b0010,4'b0010, 3'd1}, // R7 wake to lp run
    '{1,1,1,1,0,0,0,0,0, 4'b0000,4'b0000, 3'd5}, // R6 stop 1, event-wait
    '{0,0,1,0,0,0,0,0,1, 4'b0000,4'b0000, 3'd5}, // R9 first cycle consumed
    '{0,0,1,0,0,0,0,0,0, 4'b0100,4'b0000, 3'd5}, // R9 no sev-on-pend
    '{0,0,1,0,1,0,0,0,0, 4'b0100,4'b0000, 3'd1}, // R9 R7 pend wakes to lp run
    '{0,0,0,0,0,0,0,0,0, 4'b0000,4'b0000, 3'd0}, // R4 leave lp run
    '{1,1,0,0,0,0,0,0,0, 4'b0000,4'b0000, 3'd0}, // R11 request while settling
    '{0,0,0,0,0,0,0,0,0, 4'b0000,4'b0000, 3'd0},
    '{0,0,0,0,0,0,0,0,0, 4'b0000,4'b0000, 3'd0},
    '{0,0,0,0,0,0,0,0,0, 4'b0000,4'b0000, 3'd0},
    '{0,0,0,0,0,0,0,0,0, 4'b0000,4'b0000, 3'd0},
    '{0,0,0,0,0,0,0,0,0, 4'b0000,4'b0000, 3'd0},
    '{0,0,0,0,0,0,0,0,0, 4'b0000,4'b0000, 3'd0},
    '{0,0,0,0,0,0,0,0,0, 4'b0000,4'b0000, 3'd0},
    '{1,1,0,0,0,0,0,0,0, 4'b0000,4'b0000, 3'd4}, // R6 stop 0, irq-wait
    '{0,0,0,0,0,0,0,0,1, 4'b0000,4'b0000, 3'd4}, // R8 event ignored
    '{0,0,0,0,0,0,0,0,0, 4'b1000,4'b1000, 3'd0}, // R7 stop 0 to run
    '{1,0,0,1,0,0,0,0,0, 4'b0000,4'b0000, 3'd2}, // R5 sleep, event-wait
    '{0,0,0,0,0,0,0,0,0, 4'b0001,4'b0001, 3'd2}, // R9 irq ignored, consumed
    '{0,0,0,0,0,0,0,0,1, 4'b0000,4'b0000, 3'd0}, // R9 R7 event wakes to run
    '{0,0,0,0,0,1,1,0,0, 4'b0000,4'b0000, 3'd2}, // R10 re-enter sleep
    '{0,0,0,0,0,0,0,0,1, 4'b0000,4'b0000, 3'd2}, // R10 R9 event-wait kept
    '{0,0,0,0,0,0,0,0,1, 4'b0000,4'b0000, 3'd0}
  };

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    @(negedge clk);
    sleepReq = v.req; deepSel = v.deep; lpRegCtl = v.lp; waitEvt = v.evt;
    sevOnPend = v.sop; sleepOnExit = v.soe; irqReturn = v.ret; clkSlow = v.slow;
    wakeEvt = v.wev; irqPend = v.pend; irqEn = v.en;
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #800000;
    nFails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    vec_t v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.5;
    // R1 reset state
    check("R1 mode", mode, 0);
    check("R1 coreClkEn", coreClkEn, 1);
    check("R1 periphClkEn", periphClkEn, 1);
    check("R1 mainRegEn", mainRegEn, 1);
    check("R1 regLpFlag", regLpFlag, 0);
    check("R1 regSettling", regSettling, 0);
    check("R1 fullSpeedOk", fullSpeedOk, 1);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      check($sformatf("R2 mode code row %0d", i), mode, VEC[i].expMode);
      check($sformatf("R2 core clock row %0d", i), coreClkEn, VEC[i].expMode <= 3'd1);
      check($sformatf("R2 periph clock row %0d", i), periphClkEn, VEC[i].expMode <= 3'd3);
    end

    // fresh reset: sleep-on-exit with no prior request is ignored (R10)
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    v = '0; v.soe = 1; v.ret = 1;
    drive(v);
    check("R10 no prior entry", mode, 0);

    // low-power run then stop 1 (R3 R6 R2)
    v = '0; v.lp = 1; v.slow = 1;
    drive(v);
    check("R3 lp run", mode, 1);
    check("R2 lp run regLpFlag", regLpFlag, 1);
    v = '0; v.lp = 1; v.req = 1; v.deep = 1;
    drive(v);
    check("R6 stop 1", mode, 5);
    check("R2 stop 1 mainRegEn", mainRegEn, 0);
    // wake with regulator bit clear: run, settling starts (R7 R4)
    v = '0; v.pend = 4'b0001; v.en = 4'b0001;
    drive(v);
    check("R7 stop 1 to run", mode, 0);
    check("R4 mainRegEn", mainRegEn, 1);
    check("R4 regSettling start", regSettling, 1);
    check("R4 regLpFlag held", regLpFlag, 1);
    check("R4 fullSpeedOk low", fullSpeedOk, 0);
    // hold regulator bit and slow clock during settling: ignored (R11)
    for (int k = 1; k < SC; k++) begin
      v = '0; v.lp = 1; v.slow = 1;
      drive(v);
      check("R11 stay run while settling", mode, 0);
      check("R4 still settling", regSettling, 1);
    end
    v = '0;
    drive(v);
    check("R4 settle end", regSettling, 0);
    check("R4 regLpFlag end", regLpFlag, 0);
    check("R4 fullSpeedOk", fullSpeedOk, 1);
    // priority: request over re-entry over regulator change (R11)
    v = '0; v.req = 1; v.lp = 1; v.slow = 1; v.soe = 1; v.ret = 1;
    drive(v);
    check("R11 request priority", mode, 3);
    summary();
  end
endmodule